// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a free-running microsecond count for a memory-mapped timer unit. It runs on one reference clock of arbitrary frequency. A rational prescaler brings that clock down to an average rate of 1 MHz. The prescaler holds a dividend and a divisor, each stored as the value minus one. On every reference clock a phase accumulator gains the dividend. Each time the accumulator reaches the divisor, the divisor is taken back out and the count advances by one. With this scheme a reference such as 19.2 MHz gives an exact average of 1 MHz, because 5 counts are made across every 96 clocks.

Software reaches the block through a plain register port: an address, a write enable, write data, and combinational read data. The count can only be read. The ratio lives in one configuration word, which can be written and read back. Writing that word restarts the prescaler phase from zero and leaves the count untouched.

The prescaler is a small state machine with two states.
- `PS_FRESH`: the accumulator is known to be zero. The machine enters it from reset and on every configuration write. A configuration write moves the machine from either state to `PS_FRESH`.
- `PS_RUN`: the accumulator holds a running remainder. `PS_FRESH` moves to `PS_RUN` on the first clock without a configuration write. `PS_RUN` stays in `PS_RUN` on every clock without a configuration write.

Top module: `usec_timebase`

## Requirements
- R1: While reset is asserted, the count is 0 and the configuration word is 0.
- R2: A read at byte offset 0x10 returns the count, zero-extended to 32 bits. The count is CNT_W bits wide, 32 by default.
- R3: The configuration word is at byte offset 0x14. Bits [7:0] hold divisor-1 and bits [15:8] hold dividend-1. A read returns the last value written in bits [15:0], and bits [31:16] read as zero.
- R4: On each clock without a configuration write, dividend is added to the accumulator. If the sum is at least the divisor, the divisor is subtracted and the count increments on that same clock edge. No more than one increment happens per clock.
- R5: A configuration word of 0 (ratio 1/1) makes the count increment on every clock. This is the state after reset.
- R6: Word 0x000B gives 10 counts in 120 clocks, and word 0x000C gives 10 counts in 130 clocks. Word 0x045F gives exactly 10 counts in 192 clocks, and word 0x0019 gives 10 counts in 260 clocks. Each window is measured from a configuration write.
- R7: On the clock of a configuration write, the accumulator is cleared and the count holds its value without incrementing.
- R8: When the dividend exceeds the divisor, the count increments on every clock. The remainder kept after a subtraction is capped at divisor-1.
- R9: The count wraps from its maximum value (all ones) to 0 and keeps counting.
- R10: Writes to offset 0x10 and to unmapped offsets have no effect. A read of any offset other than 0x10 or 0x14 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with CNT_W = 10 and leaves the field width and offsets at their default values. The 10-bit count makes the wrap from all ones to zero reachable in about a thousand clocks instead of four billion. The 8-bit fields and the real offsets keep every ratio word from R6 exactly as software would write it. Random configuration words, including ones whose dividend exceeds the divisor, are mixed with writes to the read-only and unmapped offsets. After every clock the read data is compared against a model of the accumulator kept in the bench.

// File: rtl/utb_pkg.sv
package utb_pkg;

    // Prescaler phase state
    typedef enum logic [0:0] {
        PS_FRESH = 1'b0,   // accumulator known to be zero
        PS_RUN   = 1'b1    // accumulator holds a running remainder
    } ps_state_e;

    // Register word width of the bus
    localparam int unsigned BUS_W = 32;

    // Configuration word layout: divisor field low, dividend field above it
    localparam int unsigned CFG_FIELDS = 2;

endpackage

// File: rtl/utb_cfg_regs.sv
module utb_cfg_regs
    import utb_pkg::*;
#(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CNT_OFS = 32'h10,
    parameter int unsigned CFG_OFS = 32'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [CNT_W-1:0]   count,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               cfg_wr,
    output logic [FIELD_W-1:0] dividend_m1,
    output logic [FIELD_W-1:0] divisor_m1
);

    localparam int unsigned CFG_W = CFG_FIELDS * FIELD_W;

    logic [CFG_W-1:0] cfg_q;
    logic             hit_cnt;
    logic             hit_cfg;
    logic             unused_wdata;

    assign hit_cnt = (bus_addr == ADDR_W'(CNT_OFS));
    assign hit_cfg = (bus_addr == ADDR_W'(CFG_OFS));
    assign cfg_wr  = bus_we && hit_cfg;

    // Only the low configuration bits are stored
    assign unused_wdata = ^bus_wdata[BUS_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= bus_wdata[CFG_W-1:0];
        end
    end

    assign divisor_m1  = cfg_q[FIELD_W-1:0];
    assign dividend_m1 = cfg_q[CFG_W-1:FIELD_W];

    always_comb begin
        bus_rdata = '0;
        if (hit_cnt) begin
            bus_rdata = BUS_W'(count);
        end else if (hit_cfg) begin
            bus_rdata = BUS_W'(cfg_q);
        end
    end

endmodule

// File: rtl/utb_frac_prescaler.sv
module utb_frac_prescaler
    import utb_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [FIELD_W-1:0] dividend_m1,
    input  logic [FIELD_W-1:0] divisor_m1,
    output logic               tick,
    output logic [FIELD_W-1:0] acc
);

    localparam int unsigned SUM_W = FIELD_W + 2;

    ps_state_e        state_q;
    ps_state_e        state_d;
    logic [FIELD_W-1:0] acc_q;
    logic [FIELD_W-1:0] acc_d;
    logic [SUM_W-1:0]   step_v;
    logic [SUM_W-1:0]   den_v;
    logic [SUM_W-1:0]   base_v;
    logic [SUM_W-1:0]   sum_v;
    logic [SUM_W-1:0]   rem_v;
    logic               reach;

    // Restore the n+1 encoded fields
    assign step_v = SUM_W'(dividend_m1) + SUM_W'(1);
    assign den_v  = SUM_W'(divisor_m1) + SUM_W'(1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_FRESH;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    // Next state and outputs
    always_comb begin
        base_v  = '0;
        state_d = state_q;
        unique case (state_q)
            PS_FRESH: base_v = '0;
            PS_RUN:   base_v = SUM_W'(acc_q);
            default:  base_v = '0;
        endcase

        sum_v = base_v + step_v;
        reach = (sum_v >= den_v);
        rem_v = sum_v - den_v;

        if (clear) begin
            state_d = PS_FRESH;
            acc_d   = '0;
            tick    = 1'b0;
        end else begin
            state_d = PS_RUN;
            tick    = reach;
            if (!reach) begin
                acc_d = FIELD_W'(sum_v);
            end else if (rem_v >= den_v) begin
                acc_d = FIELD_W'(den_v - SUM_W'(1));
            end else begin
                acc_d = FIELD_W'(rem_v);
            end
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/utb_wrap_counter.sv
module utb_wrap_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import utb_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CNT_OFS = 32'h10,
    parameter int unsigned CFG_OFS = 32'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic               cfg_wr;
    logic [FIELD_W-1:0] dividend_m1;
    logic [FIELD_W-1:0] divisor_m1;
    logic               ps_tick;
    logic [FIELD_W-1:0] ps_acc;
    logic [CNT_W-1:0]   count_q;

    utb_cfg_regs #(
        .FIELD_W (FIELD_W),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W),
        .CNT_OFS (CNT_OFS),
        .CFG_OFS (CFG_OFS)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .count       (count_q),
        .bus_rdata   (bus_rdata),
        .cfg_wr      (cfg_wr),
        .dividend_m1 (dividend_m1),
        .divisor_m1  (divisor_m1)
    );

    utb_frac_prescaler #(
        .FIELD_W (FIELD_W)
    ) i_prescaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cfg_wr),
        .dividend_m1 (dividend_m1),
        .divisor_m1  (divisor_m1),
        .tick        (ps_tick),
        .acc         (ps_acc)
    );

    utb_wrap_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ps_tick),
        .count (count_q)
    );

endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CNT_OFS = 32'h10,
    parameter int unsigned CFG_OFS = 32'h14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_rdata,
    input logic               ps_tick,
    input logic [FIELD_W-1:0] ps_acc,
    input logic [FIELD_W-1:0] divisor_m1,
    input logic [CNT_W-1:0]   count_q
);

    logic cfg_hit;
    logic mapped;
    assign cfg_hit = (bus_addr == ADDR_W'(CFG_OFS));
    assign mapped  = cfg_hit || (bus_addr == ADDR_W'(CNT_OFS));

    // R1: reset holds the count at zero
    a_r1_reset_count: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);

    // R4: the count moves by exactly one after a prescaler pulse
    a_r4_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ps_tick |=> count_q == $past(count_q) + CNT_W'(1));

    // R4: without a pulse the count holds
    a_r4_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_tick |=> $stable(count_q));

    // R7: a configuration write restarts the phase and suppresses the pulse
    a_r7_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && cfg_hit) |-> (!ps_tick ##1 ps_acc == '0));

    // R8: the remainder stays below the divisor
    a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ps_acc <= divisor_m1);

    // R3: upper configuration bits read as zero
    a_r3_cfg_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |-> bus_rdata[31:16] == 16'h0);

    // R10: unmapped offsets read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == 32'h0);

endmodule

bind usec_timebase usec_timebase_chk #(
    .CNT_W   (CNT_W),
    .FIELD_W (FIELD_W),
    .ADDR_W  (ADDR_W),
    .CNT_OFS (CNT_OFS),
    .CFG_OFS (CFG_OFS)
) i_usec_timebase_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .ps_tick    (ps_tick),
    .ps_acc     (ps_acc),
    .divisor_m1 (divisor_m1),
    .count_q    (count_q)
);

// File: tb/test_usec_timebase.sv
module test_usec_timebase;

    localparam int unsigned CNT_W = 10;
    localparam logic [7:0] A_CNT = 8'h10;
    localparam logic [7:0] A_CFG = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = A_CNT;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usec_timebase #(.CNT_W(CNT_W)) i_usec_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Reference model of the requirements
    logic [CNT_W-1:0] m_cnt;
    int unsigned      m_acc;
    logic [15:0]      m_cfg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0;
            m_acc <= 0;
            m_cfg <= '0;
        end else if (bus_we && bus_addr == A_CFG) begin
            m_cfg <= bus_wdata[15:0];
            m_acc <= 0;
        end else begin
            int unsigned n, d, s;
            n = int'(m_cfg[15:8]) + 1;
            d = int'(m_cfg[7:0]) + 1;
            s = m_acc + n;
            if (s >= d) begin
                s = s - d;
                if (s >= d) s = d - 1;
                m_cnt <= m_cnt + 1'b1;
            end
            m_acc <= s;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a == A_CNT) return 32'(m_cnt);
        if (a == A_CFG) return {16'h0, m_cfg};
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle, then compare read data against the model
    task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] wd, input string tag);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic ratio(input logic [31:0] cfg, input int n_clk, input int unsigned exp_delta, input string tag);
        logic [CNT_W-1:0] c0;
        cyc(A_CFG, 1'b1, cfg, "R7");
        cyc(A_CNT, 1'b0, 32'h0, "R7");
        c0 = bus_rdata[CNT_W-1:0];
        for (int i = 0; i < n_clk; i++) cyc(A_CNT, 1'b0, 32'h0, "R4");
        check(tag, 32'(bus_rdata[CNT_W-1:0] - c0), 32'(exp_delta));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] c0;
        void'($urandom(32'd7321));

        // R1: reset state
        repeat (3) @(negedge clk);
        bus_addr = A_CNT; #1;
        check("R1", bus_rdata, 32'h0);
        bus_addr = A_CFG; #1;
        check("R1", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: default ratio counts every clock
        cyc(A_CNT, 1'b0, 32'h0, "R2");
        c0 = bus_rdata[CNT_W-1:0];
        for (int i = 0; i < 50; i++) cyc(A_CNT, 1'b0, 32'h0, "R5");
        check("R5", 32'(bus_rdata[CNT_W-1:0] - c0), 32'd50);

        // R6: fixed ratio words
        ratio(32'h0000_000B, 120, 10, "R6 12MHz");
        ratio(32'h0000_000C, 130, 10, "R6 13MHz");
        ratio(32'h0000_045F, 192, 10, "R6 19.2MHz");
        ratio(32'h0000_0019, 260, 10, "R6 26MHz");

        // R3: readback with high bits dropped
        cyc(A_CFG, 1'b1, 32'hABCD_045F, "R3");
        cyc(A_CFG, 1'b0, 32'h0, "R3");
        check("R3", bus_rdata, 32'h0000_045F);

        // R8: dividend above divisor
        ratio(32'h0000_0500, 40, 40, "R8");

        // R10: writes to count and unmapped offsets ignored
        cyc(A_CFG, 1'b1, 32'h0000_0003, "R7");
        cyc(A_CNT, 1'b1, 32'h0000_0155, "R10");
        cyc(8'h18, 1'b1, 32'hFFFF_FFFF, "R10");
        cyc(8'h18, 1'b0, 32'h0, "R10");
        check("R10", bus_rdata, 32'h0);
        cyc(A_CFG, 1'b0, 32'h0, "R10");
        check("R10", bus_rdata, 32'h0000_0003);

        // R9: wrap from all ones to zero
        cyc(A_CFG, 1'b1, 32'h0, "R7");
        for (int i = 0; i < 1100 && m_cnt != {CNT_W{1'b1}}; i++) cyc(A_CNT, 1'b0, 32'h0, "R9");
        cyc(A_CNT, 1'b0, 32'h0, "R9");
        check("R9", bus_rdata, 32'h0);
        cyc(A_CNT, 1'b0, 32'h0, "R9");
        check("R9", bus_rdata, 32'h1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [7:0] dv, dd;
            r = $urandom % 16;
            if (r == 0) begin
                dv = 8'($urandom);
                dd = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % (int'(dv) + 1));
                cyc(A_CFG, 1'b1, {$urandom} & 32'hFFFF_0000 | {16'h0, dd, dv}, "R4");
            end else if (r == 1) begin
                cyc(A_CNT, 1'b1, $urandom, "R10");
            end else if (r == 2) begin
                cyc(8'($urandom), 1'b1, $urandom, "R10");
            end else if (r < 6) begin
                cyc(8'($urandom), 1'b0, 32'h0, "R10");
            end else begin
                cyc((r % 2 == 0) ? A_CNT : A_CFG, 1'b0, 32'h0, "R4");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule